// File: doc/BRIEF.md
# PWM Maximum-Duty Static Fault Filter

This block sits on the PWM output of one controller in a group of redundant controllers. It removes the two fault classes that a fixed duty ceiling can reveal. The first is a pulse that stays high past the maximum duty limit. The second is an output stuck high or stuck low for at least one whole PWM period. A pulse under the limit passes unchanged. An over-long pulse is cut off once it has been high for the limit count. A module whose output gave no valid high time in a period is silenced for the next period. During that period the block emits a one-clock substitute pulse at the period start, so that a later voting stage still sees activity at the PWM rate.

The limit test is the comparison of the pulse with a copy of itself delayed by the limit interval. It is built as a run-length counter of consecutive high clocks. Where the input is high and the delayed copy is low, the counter has not yet reached the limit. A mode machine with three states chooses the output source:
- `ST_WAIT` holds from reset until the first period strobe. On that strobe it always moves to `ST_PASS`.
- `ST_PASS` forwards the clipped input.
- `ST_SUBST` emits only the substitute pulse.

At every period strobe the machine takes one of two transitions. *Verdict good* goes to `ST_PASS` and is taken when at least one clock of the ending period passed the limit test. *Verdict bad* goes to `ST_SUBST` and is taken otherwise. The verdict is made in both of those states, so a module that recovers returns to service after one clean period.

Top module: `pwm_duty_guard`

## Requirements
- R1: While reset is asserted and on the first clock after it, `pwm_out` is low.
- R2: Before the first `period_start` pulse after reset, `pwm_out` stays low whatever `pwm_in` does. The first strobe puts the block in pass mode for that period.
- R3: In pass mode, an input high run of at most `LIMIT_CLKS` clocks appears on `pwm_out` unchanged, one clock later. A low input with no strobe gives a low output one clock later.
- R4: In pass mode, an input high run longer than `LIMIT_CLKS` clocks is clipped. `pwm_out` is high only for the first `LIMIT_CLKS` clocks of the run, with a latency of one clock.
- R5: If no input clock passed the limit test during a period, the next period is a substitute period. `pwm_out` is high for exactly one clock, the clock after the strobe.
- R6: During a substitute period, `pwm_in` has no effect on `pwm_out`.
- R7: If at least one input clock passed the limit test during a period, pass mode applies in the next period. This holds whether that period was a pass or a substitute period.
- R8: The high-run count is not reset by `period_start`. A stuck-high input therefore gives `LIMIT_CLKS` output clocks and then a silent period. After that come substitute periods, until the input has gone low and then shown a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the PWM counter runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | High for one clock on the first clock of each PWM period |
| pwm_in | input | 1 | PWM output of the monitored controller |
| pwm_out | output | 1 | Filtered PWM, one clock behind `pwm_in` |

## Verification
The properties assume that `period_start` is a single-clock strobe that recurs every period. They also assume that `pwm_in` is synchronous to `clk`, and that reset is held long enough for the registers to clear. The stimulus follows these assumptions. A strobe is driven on offset zero of each period of fixed length, and the input pulse is built on the falling clock edge. Each pulse starts on the strobe and is one contiguous high run. Stuck-high periods are the only case in which a run spans a strobe.

// File: rtl/pwm_duty_guard_pkg.sv
package pwm_duty_guard_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_PASS  = 2'd1,
        ST_SUBST = 2'd2
    } guard_state_t;

    function automatic int unsigned duty_limit(input int unsigned period_clks,
                                               input int unsigned pct);
        return (period_clks * pct) / 100;
    endfunction

endpackage

// File: rtl/pdg_run_meter.sv
module pdg_run_meter #(
    parameter int unsigned LIMIT_CLKS = 122,
    localparam int unsigned RUN_W     = $clog2(LIMIT_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    output logic pass_ok
);

    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(LIMIT_CLKS);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!pwm_in) begin
            run_q <= '0;
        end else if (run_q != RUN_CAP) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign pass_ok = pwm_in && (run_q < RUN_CAP);

endmodule

// File: rtl/pdg_period_watch.sv
module pdg_period_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic period_start,
    input  logic pass_ok,
    output logic any_pass
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_pass <= 1'b0;
        end else if (period_start) begin
            any_pass <= pass_ok;
        end else begin
            any_pass <= any_pass | pass_ok;
        end
    end

endmodule

// File: rtl/pwm_duty_guard.sv
module pwm_duty_guard
    import pwm_duty_guard_pkg::*;
#(
    parameter int unsigned PERIOD_CLKS = 256,
    parameter int unsigned LIMIT_PCT   = 48,
    parameter int unsigned LIMIT_CLKS  = duty_limit(PERIOD_CLKS, LIMIT_PCT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_start,
    input  logic pwm_in,
    output logic pwm_out
);

    guard_state_t state;
    guard_state_t verdict;
    guard_state_t mode_now;
    logic         pass_ok;
    logic         any_pass;

    pdg_run_meter #(.LIMIT_CLKS(LIMIT_CLKS)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_in  (pwm_in),
        .pass_ok (pass_ok)
    );

    pdg_period_watch u_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .pass_ok      (pass_ok),
        .any_pass     (any_pass)
    );

    always_comb begin
        unique case (state)
            ST_WAIT:  verdict = ST_PASS;
            ST_PASS:  verdict = any_pass ? ST_PASS : ST_SUBST;
            ST_SUBST: verdict = any_pass ? ST_PASS : ST_SUBST;
            default:  verdict = ST_WAIT;
        endcase
        mode_now = period_start ? verdict : state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else if (period_start) begin
            state <= verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
        end else begin
            unique case (mode_now)
                ST_WAIT:  pwm_out <= 1'b0;
                ST_PASS:  pwm_out <= pass_ok;
                ST_SUBST: pwm_out <= period_start;
                default:  pwm_out <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_duty_guard_chk.sv
module pwm_duty_guard_chk
    import pwm_duty_guard_pkg::*;
#(
    parameter int unsigned LIMIT_CLKS = 122,
    localparam int unsigned HW = $clog2(LIMIT_CLKS + 2)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         period_start,
    input logic         pwm_in,
    input logic         pwm_out,
    input guard_state_t state
);

    logic          started;
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            hi_run  <= '0;
        end else begin
            if (period_start) started <= 1'b1;
            if (!pwm_out) hi_run <= '0;
            else if (hi_run <= HW'(LIMIT_CLKS)) hi_run <= hi_run + 1'b1;
        end
    end

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && !period_start) |=> !pwm_out);  // R2

    AST_LOW_IN_LOW_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_in && !period_start) |=> !pwm_out);  // R3

    AST_CLIP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> (hi_run < HW'(LIMIT_CLKS)));  // R4

    AST_OUT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> ($past(pwm_in) || $past(period_start)));  // R5

    AST_SUBST_ONLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUBST && !period_start) |=> !pwm_out);  // R6

endmodule

bind pwm_duty_guard pwm_duty_guard_chk #(.LIMIT_CLKS(LIMIT_CLKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .pwm_in       (pwm_in),
    .pwm_out      (pwm_out),
    .state        (state)
);

// File: tb/test_pwm_duty_guard.sv
module test_pwm_duty_guard;

    localparam int P = 32;
    localparam int L = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_start = 1'b0;
    logic pwm_in = 1'b0;
    logic pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    bit    mode_pass;
    int    run0;
    bit    pending;
    bit    exp_q;
    string tag_q;

    always #5 clk = ~clk;

    pwm_duty_guard #(.PERIOD_CLKS(P), .LIMIT_CLKS(L)) i_pwm_duty_guard (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .pwm_in(pwm_in), .pwm_out(pwm_out)
    );

    task automatic check(input bit exp, input string tag);
        checks++;
        if (pwm_out !== exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, pwm_out, exp, $time);
        end
    endtask

    task automatic step(input bit strobe, input bit din, input bit exp, input string tag);
        @(negedge clk);
        if (pending) check(exp_q, tag_q);
        period_start = strobe;
        pwm_in       = din;
        exp_q        = exp;
        tag_q        = tag;
        pending      = 1'b1;
    endtask

    task automatic do_period(input int w, input string tag);
        int passes;
        passes = L - run0;
        if (passes < 0) passes = 0;
        if (w < passes) passes = w;
        for (int t = 0; t < P; t++) begin
            step(t == 0, t < w, mode_pass ? (t < passes) : (t == 0), tag);
        end
        mode_pass = (passes > 0);
        if (w >= P) run0 = (run0 > 1000) ? run0 : run0 + P;
        else run0 = 0;
    endtask

    initial begin
        pending   = 1'b0;
        mode_pass = 1'b1;
        run0      = 0;
        repeat (3) @(negedge clk);
        check(1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        check(1'b0, "R1");
        for (int i = 0; i < 6; i++) step(1'b0, i < 4, 1'b0, "R2");
        do_period(6, "R2");
        for (int w = 0; w < P; w++) begin
            do_period(4, (w == 0) ? "R7" : "R3");
            do_period(w, (w == 0) ? "R5" : (w <= L) ? "R3" : "R4");
            if (w == 0) do_period(9, "R6");
        end
        do_period(4, "R7");
        for (int k = 0; k < 4; k++) do_period(P, "R8");
        do_period(0, "R8");
        do_period(5, "R6");
        do_period(5, "R7");
        step(1'b0, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b0, "R3");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done=0 expected=1");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule